// File: doc/BRIEF.md
# Compare-Match Event Timer

This block is a 16-bit event counter with a compare-match output, set up through four word registers on a simple synchronous bus. In time mode the counter advances on a one-cycle strobe from an external prescaler block. In pulse mode it counts edges on one of four external inputs. Those inputs pass through a two-stage synchronizer and an edge detector. Software picks the input and chooses rising or falling edges.

A match occurs when an increment arrives while the count equals the compare value. A match raises a sticky status flag, an interrupt request (gated by an enable bit) and a hardware trigger pulse. The trigger stays high until the next increment. When the compare value is zero it stays high until the timer is switched off. A mode bit chooses what happens on a match: the counter either restarts from zero or runs on and wraps at 16-bit overflow. The prescale register is only stored here. Its value is driven out to the external prescaler block.

Top module: `lpcmp_timer`

## Requirements
- R1: After reset every register reads 0, and `irq` and `hwTrig` are low.
- R2: The register word is selected by `addr[3:2]`: 0 control, 1 prescale, 2 compare, 3 count. An address with `addr[1:0]` non-zero reads 0 and a write to it has no effect. The control bits are: bit 0 run, bit 1 source (0 time, 1 pulse), bit 2 wrap mode (0 restart on match, 1 free-run), bit 3 edge sense (0 rising, 1 falling), bits 5:4 input select, bit 6 interrupt enable, bit 7 match flag. Control bits 31:8 read as 0.
- R3: Writing run=0 clears the count, the match flag and the trigger.
- R4: In time mode, each cycle with `timeTick` high advances the count by one while run is 1. A tick has no effect while run is 0, and `timeTick` has no effect in pulse mode.
- R5: In pulse mode, each selected edge on the chosen `pulseIn` bit advances the count exactly once. Edges on inputs that are not selected, and edges of the other polarity, have no effect.
- R6: With wrap mode 0, an increment that finds count equal to compare loads 0 into the count.
- R7: With wrap mode 1, the count wraps only at 16-bit overflow. The match flag is set by an increment that finds count equal to compare.
- R8: Writing 1 to control bit 7 clears the match flag. Writing 0 to bit 7 leaves the flag as it is.
- R9: `irq` is high exactly when the match flag and the interrupt-enable bit are both 1.
- R10: `hwTrig` rises on a match and falls on the next increment, unless compare is 0. With compare 0 it stays high until run is cleared.
- R11: While run is 1, writes to control bits 5:1 are ignored. Run, interrupt enable and the flag clear still take effect.
- R12: The count register returns the live count, and writes to it are ignored. The prescale register holds 7 bits, reads them back and drives `prescaleCfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register byte address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| timeTick | input | 1 | One-cycle increment strobe from the prescaler block |
| pulseIn | input | 4 | External pulse inputs (asynchronous) |
| prescaleCfg | output | 7 | Stored prescale configuration for the prescaler block |
| irq | output | 1 | Interrupt request |
| hwTrig | output | 1 | Hardware trigger |

## Verification
The hardest state to reach from the ports is the trigger with a zero compare value in free-run mode. There the trigger has to stay high while the counter moves away from the matching value, and only a sequence of increments after the match shows whether it holds. The vector table reaches it by disabling the timer and loading compare 0. It then enables free-run and applies a counted burst of ticks, so the trigger is sampled several increments after the match. Pulse-mode cases set one input at a time and wait out the synchronizer latency before reading the count. This shows that each transition counts once and that other inputs are ignored.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int CNT_W  = 16;
  localparam int NUM_IN = 4;
  localparam int SEL_W  = $clog2(NUM_IN);
  localparam int PRE_W  = 7;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  // word index taken from addr[3:2]
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_PRE  = 2'd1;
  localparam logic [1:0] REG_CMP  = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  // control word bit positions
  localparam int B_RUN  = 0;
  localparam int B_SRC  = 1;
  localparam int B_WRAP = 2;
  localparam int B_POL  = 3;
  localparam int B_SEL  = 4;
  localparam int B_IE   = 6;
  localparam int B_FLAG = 7;

  typedef struct packed {
    logic             active;
    logic             incr;
    logic             freeRun;
    logic             clrFlag;
    logic             loadCmp;
    logic [CNT_W-1:0] cmpData;
  } lpt_strobe_t;
endpackage

// File: rtl/lpt_ctrl.sv
module lpt_ctrl
  import lpt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 timeTick,
  input  logic [NUM_IN-1:0]    pulseIn,
  input  logic [CNT_W-1:0]     cntVal,
  input  logic [CNT_W-1:0]     cmpVal,
  input  logic                 flagVal,
  output logic [DATA_W-1:0]    rdData,
  output lpt_strobe_t          strb,
  output logic                 intEn,
  output logic [PRE_W-1:0]     prescaleCfg
);
  logic              enQ, srcQ, freeRunQ, polQ, ieQ;
  logic [SEL_W-1:0]  selQ;
  logic [PRE_W-1:0]  preQ;
  logic              aligned, wrCtrl, wrPre, wrCmp;
  logic [NUM_IN-1:0] syncA, syncB, prevQ, riseV, fallV;
  logic              pulseEdge, incr;
  logic              unusedBits;

  assign aligned = (addr[1:0] == 2'b00);
  assign wrCtrl  = wrEn && aligned && (addr[3:2] == REG_CTRL);
  assign wrPre   = wrEn && aligned && (addr[3:2] == REG_PRE);
  assign wrCmp   = wrEn && aligned && (addr[3:2] == REG_CMP);
  assign unusedBits = ^wrData[DATA_W-1:CNT_W];

  // configuration registers; mode fields frozen while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      srcQ     <= 1'b0;
      freeRunQ <= 1'b0;
      polQ     <= 1'b0;
      selQ     <= '0;
      ieQ      <= 1'b0;
      preQ     <= '0;
    end else begin
      if (wrCtrl) begin
        enQ <= wrData[B_RUN];
        ieQ <= wrData[B_IE];
        if (!enQ) begin
          srcQ     <= wrData[B_SRC];
          freeRunQ <= wrData[B_WRAP];
          polQ     <= wrData[B_POL];
          selQ     <= wrData[B_SEL +: SEL_W];
        end
      end
      if (wrPre) preQ <= wrData[PRE_W-1:0];
    end
  end

  // two-flop synchronizer plus one history flop per pulse input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pulseIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_edge
    assign riseV[gi] = syncB[gi] & ~prevQ[gi];
    assign fallV[gi] = ~syncB[gi] & prevQ[gi];
  end

  assign pulseEdge = polQ ? fallV[selQ] : riseV[selQ];
  assign incr      = enQ && (srcQ ? pulseEdge : timeTick);

  always_comb begin
    strb.active  = enQ;
    strb.incr    = incr;
    strb.freeRun = freeRunQ;
    strb.clrFlag = wrCtrl && wrData[B_FLAG];
    strb.loadCmp = wrCmp;
    strb.cmpData = wrData[CNT_W-1:0];
  end

  assign intEn       = ieQ;
  assign prescaleCfg = preQ;

  always_comb begin
    rdData = '0;
    if (aligned) begin
      unique case (addr[3:2])
        REG_CTRL: begin
          rdData[B_RUN]              = enQ;
          rdData[B_SRC]              = srcQ;
          rdData[B_WRAP]             = freeRunQ;
          rdData[B_POL]              = polQ;
          rdData[B_SEL +: SEL_W]     = selQ;
          rdData[B_IE]               = ieQ;
          rdData[B_FLAG]             = flagVal;
        end
        REG_PRE: rdData[PRE_W-1:0]   = preQ;
        REG_CMP: rdData[CNT_W-1:0]   = cmpVal;
        REG_CNT: rdData[CNT_W-1:0]   = cntVal;
        default: rdData = '0;
      endcase
    end
  end

  // R11
  locked_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && wrCtrl) |=> $stable({srcQ, freeRunQ, polQ, selQ}));

  // R5
  single_incr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcQ && incr) |=> !incr);
endmodule

// File: rtl/lpt_datapath.sv
module lpt_datapath
  import lpt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  lpt_strobe_t      strb,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cmpQ,
  output logic             flagQ,
  output logic             trigQ
);
  logic hit, cmpZero;

  assign hit     = (cntQ == cmpQ);
  assign cmpZero = (cmpQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      cmpQ  <= '0;
      flagQ <= 1'b0;
      trigQ <= 1'b0;
    end else begin
      if (strb.loadCmp) cmpQ <= strb.cmpData;
      if (!strb.active) begin
        cntQ  <= '0;
        flagQ <= 1'b0;
        trigQ <= 1'b0;
      end else begin
        if (strb.clrFlag) flagQ <= 1'b0;
        if (strb.incr) begin
          if (hit) begin
            flagQ <= 1'b1;
            trigQ <= 1'b1;
            cntQ  <= strb.freeRun ? cntQ + 1'b1 : '0;
          end else begin
            trigQ <= trigQ & cmpZero;
            cntQ  <= cntQ + 1'b1;
          end
        end
      end
    end
  end

  // R3
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |=> (cntQ == '0) && !flagQ && !trigQ);

  // R6
  restart_on_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && strb.incr && !strb.freeRun && hit) |=> (cntQ == '0));

  // R7
  flag_on_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && strb.incr && hit) |=> flagQ);

  // R10
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.incr) |=> $stable(trigQ));

  // R4
  hold_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.incr) |=> $stable(cntQ));
endmodule

// File: rtl/lpcmp_timer.sv
module lpcmp_timer
  import lpt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 timeTick,
  input  logic [NUM_IN-1:0]    pulseIn,
  output logic [PRE_W-1:0]     prescaleCfg,
  output logic                 irq,
  output logic                 hwTrig
);
  lpt_strobe_t      strb;
  logic [CNT_W-1:0] cntVal, cmpVal;
  logic             flagVal, trigVal, intEn;

  lpt_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .timeTick    (timeTick),
    .pulseIn     (pulseIn),
    .cntVal      (cntVal),
    .cmpVal      (cmpVal),
    .flagVal     (flagVal),
    .rdData      (rdData),
    .strb        (strb),
    .intEn       (intEn),
    .prescaleCfg (prescaleCfg)
  );

  lpt_datapath u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .cntQ  (cntVal),
    .cmpQ  (cmpVal),
    .flagQ (flagVal),
    .trigQ (trigVal)
  );

  assign irq    = flagVal & intEn;
  assign hwTrig = trigVal;

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rdData[B_FLAG] || addr[3:2] != REG_CTRL || addr[1:0] != 2'b00));
endmodule

// File: tb/lpcmp_timer_test.sv
module lpcmp_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        timeTick = 1'b0;
  logic [3:0]  pulseIn = '0;
  logic [6:0]  prescaleCfg;
  logic        irq, hwTrig;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  lpcmp_timer uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .timeTick(timeTick), .pulseIn(pulseIn),
    .prescaleCfg(prescaleCfg), .irq(irq), .hwTrig(hwTrig)
  );

  typedef struct packed {
    logic [15:0] cmp;
    logic        fr;
    logic [7:0]  n;
    logic [15:0] cnt;
    logic        flag;
    logic        trig;
  } vec_t;

  // R6 / R7 / R10 vectors: compare, wrap mode, tick count -> count, flag, trigger
  localparam vec_t VECS [10] = '{
    '{16'd3,  1'b0, 8'd2,  16'd2,  1'b0, 1'b0},
    '{16'd3,  1'b0, 8'd4,  16'd0,  1'b1, 1'b1},
    '{16'd3,  1'b0, 8'd5,  16'd1,  1'b1, 1'b0},
    '{16'd3,  1'b0, 8'd9,  16'd1,  1'b1, 1'b0},
    '{16'd0,  1'b0, 8'd5,  16'd0,  1'b1, 1'b1},
    '{16'd3,  1'b1, 8'd4,  16'd4,  1'b1, 1'b1},
    '{16'd3,  1'b1, 8'd6,  16'd6,  1'b1, 1'b0},
    '{16'd0,  1'b1, 8'd3,  16'd3,  1'b1, 1'b1},
    '{16'd10, 1'b1, 8'd10, 16'd10, 1'b0, 1'b0},
    '{16'd5,  1'b0, 8'd0,  16'd0,  1'b0, 1'b0}
  };

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); timeTick = 1'b1;
      @(negedge clk); timeTick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      readReg(4'(r * 4), rv);
      check("R1 register", rv, 32'h0);
    end
    check("R1 irq/trig", {30'd0, irq, hwTrig}, 32'h0);

    // R6 R7 R10 vector walk
    for (int v = 0; v < 10; v++) begin
      busWrite(4'h0, 32'h0);
      busWrite(4'h8, {16'h0, VECS[v].cmp});
      busWrite(4'h0, {29'd0, VECS[v].fr, 1'b0, 1'b1});
      ticks(int'(VECS[v].n));
      readReg(4'hC, rv);
      begin
        logic [31:0] cntR;
        cntR = rv;
        readReg(4'h0, rv);
        check($sformatf("R6/R7/R10 vector %0d", v),
              {cntR[15:0], 14'd0, rv[7], hwTrig},
              {VECS[v].cnt, 14'd0, VECS[v].flag, VECS[v].trig});
      end
    end

    // R2 control layout, upper bits zero, unaligned address
    busWrite(4'h0, 32'h0);
    busWrite(4'h0, 32'hFFFF_FF7E);
    readReg(4'h0, rv);
    check("R2 control readback", rv, 32'h0000_007E);
    busWrite(4'h9, 32'h0000_0055);
    readReg(4'h8, rv);
    check("R2 unaligned write ignored", rv, 32'h0000_0005);
    readReg(4'h1, rv);
    check("R2 unaligned read zero", rv, 32'h0);

    // R12 prescale register
    busWrite(4'h4, 32'hFFFF_FFFF);
    readReg(4'h4, rv);
    check("R12 prescale readback", rv, 32'h7F);
    check("R12 prescale port", {25'd0, prescaleCfg}, 32'h7F);

    // R11 locked fields, R12 count write ignored
    busWrite(4'h0, 32'h0);
    busWrite(4'h8, 32'd100);
    busWrite(4'h0, 32'h1);
    busWrite(4'h0, 32'h3F);
    readReg(4'h0, rv);
    check("R11 fields frozen", rv, 32'h1);
    ticks(3);
    busWrite(4'hC, 32'h1234);
    readReg(4'hC, rv);
    check("R12 count write ignored", rv, 32'd3);

    // R4 ticks ignored while stopped
    busWrite(4'h0, 32'h0);
    ticks(3);
    readReg(4'hC, rv);
    check("R4 stopped ignores ticks", rv, 32'd0);

    // R8 R9 flag, clear and interrupt
    busWrite(4'h8, 32'd2);
    busWrite(4'h0, 32'h41);
    ticks(3);
    settle();
    check("R9 irq on flag", {31'd0, irq}, 32'd1);
    busWrite(4'h0, 32'h41);
    readReg(4'h0, rv);
    check("R8 write 0 keeps flag", rv, 32'hC1);
    busWrite(4'h0, 32'hC1);
    readReg(4'h0, rv);
    check("R8 flag cleared", rv, 32'h41);
    check("R9 irq follows clear", {31'd0, irq}, 32'd0);
    busWrite(4'h0, 32'h01);
    ticks(3);
    settle();
    check("R9 irq masked", {30'd0, irq, hwTrig}, 32'd1);

    // R3 stop clears count, flag, trigger
    ticks(1);
    busWrite(4'h0, 32'h0);
    settle();
    readReg(4'hC, rv);
    check("R3 count cleared", rv, 32'd0);
    readReg(4'h0, rv);
    check("R3 flag/trig cleared", {rv[7], hwTrig}, 32'd0);

    // R5 pulse mode, input 2, rising edges
    busWrite(4'h0, 32'h23);
    ticks(2);
    readReg(4'hC, rv);
    check("R4 tick ignored in pulse mode", rv, 32'd0);
    @(negedge clk) pulseIn[2] = 1'b1; settle();
    readReg(4'hC, rv);
    check("R5 rising counted", rv, 32'd1);
    @(negedge clk) pulseIn[2] = 1'b0; settle();
    readReg(4'hC, rv);
    check("R5 falling ignored", rv, 32'd1);
    @(negedge clk) pulseIn[0] = 1'b1; settle();
    @(negedge clk) pulseIn[0] = 1'b0; settle();
    readReg(4'hC, rv);
    check("R5 other input ignored", rv, 32'd1);
    @(negedge clk) pulseIn[2] = 1'b1; settle();
    readReg(4'hC, rv);
    check("R5 second rising", rv, 32'd2);
    @(negedge clk) pulseIn[2] = 1'b0;

    // R5 falling sense on input 1
    busWrite(4'h0, 32'h0);
    busWrite(4'h0, 32'h1B);
    @(negedge clk) pulseIn[1] = 1'b1; settle();
    readReg(4'hC, rv);
    check("R5 rise ignored in falling sense", rv, 32'd0);
    @(negedge clk) pulseIn[1] = 1'b0; settle();
    readReg(4'hC, rv);
    check("R5 fall counted", rv, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule